// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a 16-bit write bus and the controller that erases and programs an embedded flash array. It watches every bus write and recognises multi-cycle command sequences. Each sequence opens with a fixed two-write unlock handshake and is followed by the command code. When a sequence is complete and legal, the block sends a single-cycle start pulse to the controller, together with the kind of operation, the target address and the data word. Erase suspend, erase resume and read/reset are single writes that need no unlock handshake. These produce suspend, resume and abort pulses.

Which writes the block acts on depends on what the controller is doing. The block tracks this as one of four modes: idle read, operation running, erase suspended, and program running inside a suspended erase. Any write that breaks a sequence sends the sequence tracker back to its first cycle. Targets in protected blocks are refused. A read-source select tells the bus whether a read returns array data or the controller's status word.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no pulse output is high, `rd_status` is 0 and the block is in read mode.
- R2: The unlock handshake is data low byte 0xAA written at word address 0x1554, then low byte 0x55 written at 0x2AA8. Only bits 7:0 of the data are compared.
- R3: Chip erase is unlock, 0x80 at 0x1554, unlock, 0x10 at 0x1554. The final write gives `op_start` with `op_kind` = 2.
- R4: Block erase is unlock, 0x80 at 0x1554, unlock, then 0x30 at any address. It gives `op_start` with `op_kind` = 1 and `op_addr` set to that address. The block index is `addr[15:13]`.
- R5: Program word is unlock, 0xA0 at 0x1554, then one write of the data. It gives `op_start` with `op_kind` = 0, `op_addr` set to the write address and `op_data` set to the full written word.
- R6: A wrong address or a wrong code on any cycle of a sequence ends it with no pulse. The next correct sequence is then recognised from its first cycle.
- R7: While an operation runs, `rd_status` is 1 and only two writes act. 0xF0 gives `op_abort` and returns to read mode. 0xB0 gives `op_suspend`, and only when the running operation is an erase. All other writes are ignored. `ctrl_done` returns the block to read mode.
- R8: Suspend (0xB0) and resume (0x30) are single writes at any address. Resume acts only in the suspended state and gives `op_resume`, after which `rd_status` is 1 again. In suspend, and in read mode, `rd_status` is 0.
- R9: In suspend, only a program word to a block other than the one being erased is started. It is refused after a chip erase. While that program runs, `rd_status` is 1, and `ctrl_done` returns the block to suspend. Erase sequences in suspend are ignored.
- R10: 0xF0 in suspend gives `op_abort` and returns to read mode. A later 0x30 does nothing.
- R11: Block erase or program word whose target block has its bit set in `prot_mask` is refused with no pulse.
- R12: Every pulse is high for exactly one cycle, in the cycle after the write that caused it. At most one pulse is high per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 16 | Word address of the write |
| wr_data | input | 16 | Write data; bits 7:0 carry command codes |
| ctrl_done | input | 1 | Controller finished the running operation |
| prot_mask | input | 8 | Per-block protection, 1 = protected |
| op_start | output | 1 | Start pulse to the controller |
| op_kind | output | 2 | 0 program, 1 block erase, 2 chip erase |
| op_addr | output | 16 | Address of the started operation |
| op_data | output | 16 | Data word of the started operation |
| op_suspend | output | 1 | Suspend-erase pulse |
| op_resume | output | 1 | Resume-erase pulse |
| op_abort | output | 1 | Abort pulse |
| rd_status | output | 1 | 1 = reads return the status word |

## Verification
A corrupted mode register shows up at the next edge as a wrong `rd_status` level. It also shows up at the next command as a pulse that should have been refused, or as a missing suspend, resume or abort. A tracker stuck in a middle cycle only shows when the next sequence starts: that sequence gives no start pulse, or fires one cycle too early. The bench therefore follows every ignored or malformed stimulus with either a `rd_status` sample or a fresh legal sequence. This keeps a bad state from staying hidden for more than one command.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    OPK_PROG       = 2'd0,
    OPK_BLK_ERASE  = 2'd1,
    OPK_CHIP_ERASE = 2'd2
  } op_kind_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_ERS_ARM,
    SQ_ERS_UNL1,
    SQ_ERS_UNL2,
    SQ_PRG_DATA
  } seq_st_t;

  typedef enum logic [1:0] {
    MD_READ,
    MD_BUSY,
    MD_SUSP,
    MD_SUSP_PRG
  } mode_t;

  localparam logic [7:0] CODE_KEY_A     = 8'hAA;
  localparam logic [7:0] CODE_KEY_B     = 8'h55;
  localparam logic [7:0] CODE_ERASE_ARM = 8'h80;
  localparam logic [7:0] CODE_CHIP      = 8'h10;
  localparam logic [7:0] CODE_BLOCK     = 8'h30;
  localparam logic [7:0] CODE_PROG      = 8'hA0;
  localparam logic [7:0] CODE_RESET     = 8'hF0;
  localparam logic [7:0] CODE_SUSPEND   = 8'hB0;
  localparam logic [7:0] CODE_RESUME    = 8'h30;

endpackage

// File: rtl/flash_seq_tracker.sv
module flash_seq_tracker
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 'h1554,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 'h2AA8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_lo,
  output logic              seq_idle,
  output logic              cmd_valid,
  output op_kind_t          cmd_kind
);

  seq_st_t st_q, st_d;
  logic    st_en;
  logic    at_a, at_b;

  assign at_a  = (wr_addr == KEY_ADDR_A);
  assign at_b  = (wr_addr == KEY_ADDR_B);
  assign st_en = hold | wr_en;

  always_comb begin
    st_d      = st_q;
    cmd_valid = 1'b0;
    cmd_kind  = OPK_PROG;
    if (hold) begin
      st_d = SQ_IDLE;
    end else if (wr_en) begin
      st_d = SQ_IDLE;
      case (st_q)
        SQ_IDLE:     if (at_a && wr_lo == CODE_KEY_A) st_d = SQ_UNL1;
        SQ_UNL1:     if (at_b && wr_lo == CODE_KEY_B) st_d = SQ_UNL2;
        SQ_UNL2: begin
          if (at_a && wr_lo == CODE_ERASE_ARM)  st_d = SQ_ERS_ARM;
          else if (at_a && wr_lo == CODE_PROG)  st_d = SQ_PRG_DATA;
        end
        SQ_ERS_ARM:  if (at_a && wr_lo == CODE_KEY_A) st_d = SQ_ERS_UNL1;
        SQ_ERS_UNL1: if (at_b && wr_lo == CODE_KEY_B) st_d = SQ_ERS_UNL2;
        SQ_ERS_UNL2: begin
          if (at_a && wr_lo == CODE_CHIP) begin
            cmd_valid = 1'b1;
            cmd_kind  = OPK_CHIP_ERASE;
          end else if (wr_lo == CODE_BLOCK) begin
            cmd_valid = 1'b1;
            cmd_kind  = OPK_BLK_ERASE;
          end
        end
        SQ_PRG_DATA: begin
          cmd_valid = 1'b1;
          cmd_kind  = OPK_PROG;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= SQ_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign seq_idle = (st_q == SQ_IDLE);

  assert_hold_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> seq_idle);

  assert_cmd_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> seq_idle);

  assert_key_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_UNL1) |-> ($past(wr_en) || $past(st_q) == SQ_UNL1));

endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 3,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_lo,
  input  logic               seq_idle,
  input  logic               cmd_valid,
  input  op_kind_t           cmd_kind,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [15:0]        cmd_data,
  input  logic [NUM_BLK-1:0] prot_mask,
  input  logic               ctrl_done,
  output logic               hold,
  output logic               op_start,
  output op_kind_t           op_kind,
  output logic [ADDR_W-1:0]  op_addr,
  output logic [15:0]        op_data,
  output logic               op_suspend,
  output logic               op_resume,
  output logic               op_abort,
  output logic               rd_status
);

  mode_t            mode_q, mode_d;
  logic [BLK_W-1:0] susp_blk_q, susp_blk_d;
  logic             cur_erase_q, cur_erase_d;
  logic             cur_chip_q, cur_chip_d;
  logic             start_d, susp_d, res_d, abort_d;
  logic [BLK_W-1:0] cmd_blk;
  logic             cmd_ok, wr_reset, wr_susp, wr_resume;

  assign cmd_blk   = cmd_addr[ADDR_W-1 -: BLK_W];
  assign cmd_ok    = cmd_valid && (cmd_kind == OPK_CHIP_ERASE || !prot_mask[cmd_blk]);
  assign wr_reset  = wr_en && (wr_lo == CODE_RESET);
  assign wr_susp   = wr_en && (wr_lo == CODE_SUSPEND);
  assign wr_resume = wr_en && (wr_lo == CODE_RESUME);
  assign hold      = (mode_q == MD_BUSY) || (mode_q == MD_SUSP_PRG);

  always_comb begin
    mode_d      = mode_q;
    susp_blk_d  = susp_blk_q;
    cur_erase_d = cur_erase_q;
    cur_chip_d  = cur_chip_q;
    start_d     = 1'b0;
    susp_d      = 1'b0;
    res_d       = 1'b0;
    abort_d     = 1'b0;
    case (mode_q)
      MD_READ: begin
        if (cmd_ok) begin
          start_d     = 1'b1;
          mode_d      = MD_BUSY;
          cur_erase_d = (cmd_kind != OPK_PROG);
          cur_chip_d  = (cmd_kind == OPK_CHIP_ERASE);
          susp_blk_d  = cmd_blk;
        end
      end
      MD_BUSY: begin
        if (ctrl_done) begin
          mode_d = MD_READ;
        end else if (wr_reset) begin
          abort_d = 1'b1;
          mode_d  = MD_READ;
        end else if (wr_susp && cur_erase_q) begin
          susp_d = 1'b1;
          mode_d = MD_SUSP;
        end
      end
      MD_SUSP: begin
        if (seq_idle && wr_resume) begin
          res_d  = 1'b1;
          mode_d = MD_BUSY;
        end else if (seq_idle && wr_reset) begin
          abort_d = 1'b1;
          mode_d  = MD_READ;
        end else if (cmd_ok && cmd_kind == OPK_PROG && !cur_chip_q &&
                     cmd_blk != susp_blk_q) begin
          start_d = 1'b1;
          mode_d  = MD_SUSP_PRG;
        end
      end
      MD_SUSP_PRG: begin
        if (ctrl_done) mode_d = MD_SUSP;
      end
      default: mode_d = MD_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MD_READ;
      susp_blk_q  <= '0;
      cur_erase_q <= 1'b0;
      cur_chip_q  <= 1'b0;
      op_start    <= 1'b0;
      op_suspend  <= 1'b0;
      op_resume   <= 1'b0;
      op_abort    <= 1'b0;
      rd_status   <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      susp_blk_q  <= susp_blk_d;
      cur_erase_q <= cur_erase_d;
      cur_chip_q  <= cur_chip_d;
      op_start    <= start_d;
      op_suspend  <= susp_d;
      op_resume   <= res_d;
      op_abort    <= abort_d;
      rd_status   <= (mode_d == MD_BUSY) || (mode_d == MD_SUSP_PRG);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_kind <= OPK_PROG;
      op_addr <= '0;
      op_data <= '0;
    end else if (start_d) begin
      op_kind <= cmd_kind;
      op_addr <= cmd_addr;
      op_data <= cmd_data;
    end
  end

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({op_start, op_suspend, op_resume, op_abort}) <= 1);

  assert_start_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  assert_start_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> rd_status);

  assert_susp_from_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_suspend |-> (!rd_status && $past(rd_status)));

  assert_resume_to_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_resume |-> (rd_status && !$past(rd_status)));

  assert_abort_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_abort |-> !rd_status);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 3,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [15:0]        wr_data,
  input  logic               ctrl_done,
  input  logic [NUM_BLK-1:0] prot_mask,
  output logic               op_start,
  output logic [1:0]         op_kind,
  output logic [ADDR_W-1:0]  op_addr,
  output logic [15:0]        op_data,
  output logic               op_suspend,
  output logic               op_resume,
  output logic               op_abort,
  output logic               rd_status
);

  logic     hold, seq_idle, cmd_valid;
  op_kind_t cmd_kind, kind_q;

  flash_seq_tracker #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_lo     (wr_data[7:0]),
    .seq_idle  (seq_idle),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind)
  );

  flash_mode_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_lo      (wr_data[7:0]),
    .seq_idle   (seq_idle),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .cmd_addr   (wr_addr),
    .cmd_data   (wr_data),
    .prot_mask  (prot_mask),
    .ctrl_done  (ctrl_done),
    .hold       (hold),
    .op_start   (op_start),
    .op_kind    (kind_q),
    .op_addr    (op_addr),
    .op_data    (op_data),
    .op_suspend (op_suspend),
    .op_resume  (op_resume),
    .op_abort   (op_abort),
    .rd_status  (rd_status)
  );

  assign op_kind = kind_q;

endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/100ps
module test_flash_cmd_decoder;

  localparam int EV_START = 1, EV_SUSP = 2, EV_RES = 3, EV_ABORT = 4;

  typedef struct {
    int          ev;
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [15:0] data;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, ctrl_done;
  logic [15:0] wr_addr, wr_data;
  logic [7:0]  prot_mask;
  logic        op_start, op_suspend, op_resume, op_abort, rd_status;
  logic [1:0]  op_kind;
  logic [15:0] op_addr, op_data;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_done(ctrl_done), .prot_mask(prot_mask),
    .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .op_suspend(op_suspend), .op_resume(op_resume),
    .op_abort(op_abort), .rd_status(rd_status)
  );

  task automatic expect_ev(int ev, logic [1:0] k, logic [15:0] a,
                           logic [15:0] d, string req);
    exp_t e;
    e.ev = ev; e.kind = k; e.addr = a; e.data = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h1554, 16'h00AA);
    wr(16'h2AA8, 16'h0055);
  endtask

  task automatic erase_arm();
    unlock();
    wr(16'h1554, 16'h0080);
    unlock();
  endtask

  task automatic done_pulse();
    @(negedge clk);
    ctrl_done = 1'b1;
    @(negedge clk);
    ctrl_done = 1'b0;
  endtask

  task automatic check_rd(logic e, string req);
    n_vec++;
    if (rd_status !== e) begin
      n_bad++;
      $display("FAIL %s: rd_status got %0b expected %0b", req, rd_status, e);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Monitor: pops one expected item per observed pulse
  initial begin
    exp_t e;
    int   cnt, got;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n === 1'b1) begin
        cnt = int'(op_start) + int'(op_suspend) + int'(op_resume) + int'(op_abort);
        got = op_start ? EV_START : op_suspend ? EV_SUSP : op_resume ? EV_RES : EV_ABORT;
        if (cnt > 1) begin
          n_vec++; n_bad++;
          $display("FAIL R12: %0d pulses in one cycle, expected at most 1", cnt);
        end else if (cnt == 1) begin
          n_vec++;
          if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R7/R9/R11: unexpected pulse %0d, expected none", got);
          end else begin
            e = exp_q.pop_front();
            if (got != e.ev || (got == EV_START &&
                (op_kind !== e.kind || op_addr !== e.addr || op_data !== e.data))) begin
              n_bad++;
              $display("FAIL %s: got ev %0d kind %0d addr %h data %h, expected ev %0d kind %0d addr %h data %h",
                       e.req, got, op_kind, op_addr, op_data, e.ev, e.kind, e.addr, e.data);
            end
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; ctrl_done = 1'b0;
    wr_addr = '0; wr_data = '0; prot_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    n_vec++;
    if ({op_start, op_suspend, op_resume, op_abort, rd_status} !== 5'b0) begin
      n_bad++;
      $display("FAIL R1: outputs got %b expected 00000",
               {op_start, op_suspend, op_resume, op_abort, rd_status});
    end
    check_rd(1'b0, "R1");

    // R2/R5: program word, upper data byte of coded cycles is don't-care
    wr(16'h1554, 16'hFFAA);
    wr(16'h2AA8, 16'h1255);
    wr(16'h1554, 16'h33A0);
    expect_ev(EV_START, 2'd0, 16'h4010, 16'h1234, "R5");
    wr(16'h4010, 16'h1234);
    check_rd(1'b1, "R5");
    wr(16'h0000, 16'h00B0);          // R7: suspend of a program is ignored
    check_rd(1'b1, "R7");
    done_pulse();
    check_rd(1'b0, "R7");

    // R8: resume and suspend in read mode do nothing
    wr(16'h0100, 16'h0030);
    wr(16'h0100, 16'h00B0);
    check_rd(1'b0, "R8");

    // R6: malformed sequences
    unlock();
    wr(16'h1554, 16'h0081);
    wr(16'h1554, 16'h00AA);
    wr(16'h2AA8, 16'h0055);
    wr(16'h1554, 16'h0010);
    check_rd(1'b0, "R6");
    wr(16'h1554, 16'h00AA);
    wr(16'h2AA9, 16'h0055);
    wr(16'h1554, 16'h00A0);
    wr(16'h4000, 16'h0001);
    check_rd(1'b0, "R6");
    erase_arm();
    wr(16'h1554, 16'h0020);
    check_rd(1'b0, "R6");
    unlock();
    wr(16'h1554, 16'h00A0);
    expect_ev(EV_START, 2'd0, 16'h5002, 16'hABCD, "R6");
    wr(16'h5002, 16'hABCD);
    check_rd(1'b1, "R6");
    done_pulse();

    // R3: chip erase, R7: busy filtering and abort
    erase_arm();
    expect_ev(EV_START, 2'd2, 16'h1554, 16'h0010, "R3");
    wr(16'h1554, 16'h0010);
    check_rd(1'b1, "R3");
    unlock();
    wr(16'h1554, 16'h00A0);
    wr(16'h4000, 16'h5555);
    wr(16'h0000, 16'h0030);
    check_rd(1'b1, "R7");
    expect_ev(EV_ABORT, 2'd0, 16'h0, 16'h0, "R7");
    wr(16'h3333, 16'h00F0);
    check_rd(1'b0, "R7");

    // R4: block erase, R8/R9/R10: suspend behaviour
    erase_arm();
    expect_ev(EV_START, 2'd1, 16'h4100, 16'h0030, "R4");
    wr(16'h4100, 16'h0030);
    check_rd(1'b1, "R4");
    expect_ev(EV_SUSP, 2'd0, 16'h0, 16'h0, "R8");
    wr(16'h9999, 16'h00B0);
    check_rd(1'b0, "R8");
    unlock();
    wr(16'h1554, 16'h00A0);
    wr(16'h4200, 16'h1111);          // same block: refused
    check_rd(1'b0, "R9");
    erase_arm();
    wr(16'h8000, 16'h0030);          // erase in suspend: refused
    check_rd(1'b0, "R9");
    unlock();
    wr(16'h1554, 16'h00A0);
    expect_ev(EV_START, 2'd0, 16'hA000, 16'hBEEF, "R9");
    wr(16'hA000, 16'hBEEF);
    check_rd(1'b1, "R9");
    wr(16'h0000, 16'h0030);          // ignored while program runs
    check_rd(1'b1, "R9");
    done_pulse();
    check_rd(1'b0, "R9");
    expect_ev(EV_RES, 2'd0, 16'h0, 16'h0, "R8");
    wr(16'h7777, 16'h0030);
    check_rd(1'b1, "R8");
    expect_ev(EV_SUSP, 2'd0, 16'h0, 16'h0, "R8");
    wr(16'h0000, 16'h00B0);
    expect_ev(EV_ABORT, 2'd0, 16'h0, 16'h0, "R10");
    wr(16'h0000, 16'h00F0);
    check_rd(1'b0, "R10");
    wr(16'h0000, 16'h0030);
    check_rd(1'b0, "R10");

    // R11: protection
    prot_mask = 8'h08;
    erase_arm();
    wr(16'h6000, 16'h0030);
    check_rd(1'b0, "R11");
    unlock();
    wr(16'h1554, 16'h00A0);
    wr(16'h7000, 16'h2222);
    check_rd(1'b0, "R11");
    unlock();
    wr(16'h1554, 16'h00A0);
    expect_ev(EV_START, 2'd0, 16'h8000, 16'h4444, "R11");
    wr(16'h8000, 16'h4444);
    check_rd(1'b1, "R11");
    done_pulse();

    repeat (3) @(negedge clk);
    while (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++; n_bad++;
      $display("FAIL %s: pulse %0d never seen, expected one", e.req, e.ev);
    end
    summary();
    $finish;
  end

endmodule